// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block steers a horizontally microcoded controller through a 512-word control store. Each cycle it takes the control fields of the microinstruction being executed, the sign and zero results of that microinstruction's ALU operation, and the opcode byte last fetched from the instruction stream. From these it forms the 9-bit microprogram address of the next microinstruction.

The block uses no adder or comparator. A conditional branch is built by ORing the selected condition flags into the top address bit. The two possible targets of a branch are therefore always 0x100 apart. Opcode dispatch is built by ORing the opcode byte into the low eight address bits. The microprogram address register is loaded on the rising clock edge, together with the latched flags. The microinstruction register then captures the addressed control-store word on the following falling edge. The control store itself sits outside the block and returns a word for the address the block presents.

The sequencer is controlled by a four-way selection. **PASS** copies the next-address field unchanged. **BRANCH** forms the top bit from the flags. **DISPATCH** merges the opcode into the low byte. **BRANCH_DISPATCH** does both at once. The selection is made again from each new microinstruction; every selection can follow every other one.

Top module: `useq_sequencer`

## Requirements
- R1: While reset is asserted, the microprogram address is 0 and the microinstruction register holds the all-zero word. The first rising edge after reset releases forms address 0.
- R2: The microinstruction word is laid out as follows: bits [8:0] next-address field, bit 9 dispatch enable, bit 10 sign-branch enable, bit 11 zero-branch enable, bits [19:12] data-path control. With all three enables at 0, the next address equals the next-address field.
- R3: Bit 8 of the next address is (sign-branch enable AND sign flag) OR (zero-branch enable AND zero flag) OR field bit 8. A flag whose enable is 0 has no effect.
- R4: Both branch enables may be 1 in the same word; bit 8 is then set if either enabled flag is 1. Branching may also be combined with dispatch.
- R5: With dispatch enable at 1, bits [7:0] of the next address are the field's bits [7:0] ORed with the opcode byte.
- R6: With dispatch enable at 0, the opcode byte has no effect on the next address.
- R7: On each falling edge outside reset, the microinstruction register captures the control-store word addressed by the current microprogram address. It holds that word until the next falling edge.
- R8: The flags used for a branch are the ALU flags presented at the rising edge that forms the address, which means they come from the same microinstruction. The latched flag outputs show those same values after that edge.
- R9: All nine bits of the formed address are kept, so targets in the upper half (0x100 to 0x1FF) are reached both by branch and by dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge forms the address, falling edge loads the microinstruction |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_n | input | 1 | Sign result of the current microinstruction's ALU operation |
| alu_z | input | 1 | Zero result of the current microinstruction's ALU operation |
| mbr_opcode | input | 8 | Fetched opcode byte used for dispatch |
| cs_word | input | 20 | Control-store word at address `mpc` |
| mpc | output | 9 | Microprogram address presented to the control store |
| mir_word | output | 20 | Current microinstruction |
| flag_n | output | 1 | Latched sign flag |
| flag_z | output | 1 | Latched zero flag |

## Verification
The two functions that can act in the same cycle are the flag-driven branch on the top bit and the opcode merge on the low byte. The bench provokes this with a word that sets both the zero-branch enable and the dispatch enable. It drives a true zero flag and a non-zero opcode, so the expected target has bit 8 taken from the flag and bits [7:0] taken from the opcode. A second combined case sets both branch enables and drives both flags high. Each formed address is compared against a value predicted from the word layout, one rising edge after the flags and opcode are applied. The word loaded on the following falling edge is compared as well.

// File: rtl/useq_pkg.sv
package useq_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    parameter int ADDR_W = 9;
    parameter int CTRL_W = 8;
    localparam int OPC_W = ADDR_W - 1;
    localparam int MIR_W = ADDR_W + 3 + CTRL_W;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              jam_zero;
        logic              jam_sign;
        logic              dispatch;
        logic [ADDR_W-1:0] next_addr;
    } uinstr_t;

    typedef enum logic [1:0] {
        SEL_PASS            = 2'd0,
        SEL_BRANCH          = 2'd1,
        SEL_DISPATCH        = 2'd2,
        SEL_BRANCH_DISPATCH = 2'd3
    } addr_sel_e;
endpackage

// File: rtl/useq_addr_logic.sv
module useq_addr_logic
    import useq_pkg::*;
(
    input  uinstr_t           mir,
    input  logic              sign_in,
    input  logic              zero_in,
    input  logic [OPC_W-1:0]  opcode,
    output logic [ADDR_W-1:0] next_mpc,
    output addr_sel_e         sel
);
    timeunit 1ns;
    timeprecision 1ps;

    logic top_bit;
    logic [OPC_W-1:0] low_field;

    always_comb begin
        low_field = mir.next_addr[OPC_W-1:0];
        top_bit   = (mir.jam_sign & sign_in) | (mir.jam_zero & zero_in)
                  | mir.next_addr[ADDR_W-1];
        sel = addr_sel_e'({mir.dispatch, mir.jam_sign | mir.jam_zero});
    end

    always_comb begin
        unique case (sel)
            SEL_PASS:            next_mpc = mir.next_addr;
            SEL_BRANCH:          next_mpc = {top_bit, low_field};
            SEL_DISPATCH:        next_mpc = {mir.next_addr[ADDR_W-1], low_field | opcode};
            SEL_BRANCH_DISPATCH: next_mpc = {top_bit, low_field | opcode};
            default:             next_mpc = mir.next_addr;
        endcase
    end
endmodule

// File: rtl/useq_mir_reg.sv
module useq_mir_reg
    import useq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  uinstr_t word_in,
    output uinstr_t word_q
);
    timeunit 1ns;
    timeprecision 1ps;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_in;
    end

    // R7: each falling edge captures the word presented at the previous one
    assert_mir_load_R7: assert property (@(negedge clk) disable iff (!rst_n)
        1'b1 |=> word_q == $past(word_in));
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alu_n,
    input  logic                 alu_z,
    input  logic [7:0]           mbr_opcode,
    input  logic [19:0]          cs_word,
    output logic [8:0]           mpc,
    output logic [19:0]          mir_word,
    output logic                 flag_n,
    output logic                 flag_z
);
    timeunit 1ns;
    timeprecision 1ps;

    uinstr_t           mir_q;
    logic [ADDR_W-1:0] mpc_d;
    addr_sel_e         sel;

    useq_addr_logic u_addr (
        .mir      (mir_q),
        .sign_in  (alu_n),
        .zero_in  (alu_z),
        .opcode   (mbr_opcode),
        .next_mpc (mpc_d),
        .sel      (sel)
    );

    useq_mir_reg u_mir (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_in (uinstr_t'(cs_word)),
        .word_q  (mir_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mpc    <= '0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
        end else begin
            mpc    <= mpc_d;
            flag_n <= alu_n;
            flag_z <= alu_z;
        end
    end

    always_comb mir_word = mir_q;

    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mir_q.dispatch && !mir_q.jam_sign && !mir_q.jam_zero)
        |=> mpc == $past(mir_q.next_addr));

    assert_top_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> mpc[ADDR_W-1] == $past((mir_q.jam_sign & alu_n)
                 | (mir_q.jam_zero & alu_z) | mir_q.next_addr[ADDR_W-1]));

    assert_dispatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mir_q.dispatch |=> mpc[OPC_W-1:0] ==
                           $past(mir_q.next_addr[OPC_W-1:0] | mbr_opcode));

    assert_opcode_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mir_q.dispatch |=> mpc[OPC_W-1:0] == $past(mir_q.next_addr[OPC_W-1:0]));

    assert_flags_same_uinstr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flag_n == $past(alu_n)) && (flag_z == $past(alu_z)));

    assert_sel_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mir_q.jam_sign && mir_q.jam_zero) |-> (sel == SEL_BRANCH || sel == SEL_BRANCH_DISPATCH));
endmodule

// File: tb/useq_sequencer_bench.sv
module useq_sequencer_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alu_n = 1'b0;
    logic        alu_z = 1'b0;
    logic [7:0]  mbr_opcode = 8'h00;
    logic [19:0] cs_word;
    logic [8:0]  mpc;
    logic [19:0] mir_word;
    logic        flag_n;
    logic        flag_z;

    logic [19:0] rom [512];
    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    logic [8:0] exp_q [$];
    logic       expn_q [$];
    logic       expz_q [$];
    string      tag_q [$];
    logic [19:0] model_mir = '0;

    always #10 clk = ~clk;

    assign cs_word = rom[mpc];

    useq_sequencer u_useq_sequencer (
        .clk(clk), .rst_n(rst_n), .alu_n(alu_n), .alu_z(alu_z),
        .mbr_opcode(mbr_opcode), .cs_word(cs_word), .mpc(mpc),
        .mir_word(mir_word), .flag_n(flag_n), .flag_z(flag_z)
    );

    // word layout (R2): [19:12] ctrl, 11 zero-branch, 10 sign-branch, 9 dispatch, [8:0] next
    function automatic logic [19:0] mk(input logic jz, input logic jn,
                                       input logic dsp, input logic [8:0] na);
        return {8'h5A, jz, jn, dsp, na};
    endfunction

    function automatic logic [8:0] predict(input logic [19:0] w, input logic n,
                                           input logic z, input logic [7:0] op);
        logic hi;
        logic [7:0] lo;
        hi = (w[10] & n) | (w[11] & z) | w[8];
        lo = w[9] ? (w[7:0] | op) : w[7:0];
        return {hi, lo};
    endfunction

    task automatic check(input bit ok, input string req, input logic [19:0] act,
                         input logic [19:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic n, input logic z, input logic [7:0] op,
                        input string tag);
        logic [8:0] e;
        e = predict(model_mir, n, z, op);
        alu_n = n;
        alu_z = z;
        mbr_opcode = op;
        exp_q.push_back(e);
        expn_q.push_back(n);
        expz_q.push_back(z);
        tag_q.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        #2;
        model_mir = rom[e];
        check(mir_word == model_mir, "R7", mir_word, model_mir);
    endtask

    // monitor: compares each formed address after the rising edge
    always begin
        @(posedge clk);
        #3;
        if (exp_q.size() != 0) begin
            logic [8:0] e;
            logic en, ez;
            string t;
            e = exp_q.pop_front();
            en = expn_q.pop_front();
            ez = expz_q.pop_front();
            t = tag_q.pop_front();
            check(mpc == e, t, {11'd0, mpc}, {11'd0, e});
            check(flag_n == en && flag_z == ez, "R8",
                  {18'd0, flag_n, flag_z}, {18'd0, en, ez});
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) rom[i] = mk(1'b0, 1'b0, 1'b0, 9'((i + 1) % 512));
        rom[9'h000] = mk(0, 0, 0, 9'h005);
        rom[9'h005] = mk(0, 1, 0, 9'h010);
        rom[9'h110] = mk(1, 0, 0, 9'h020);
        rom[9'h120] = mk(1, 1, 0, 9'h030);
        rom[9'h130] = mk(0, 0, 1, 9'h000);
        rom[9'h07F] = mk(0, 0, 1, 9'h100);
        rom[9'h1A5] = mk(0, 0, 0, 9'h0FF);
        rom[9'h0FF] = mk(0, 1, 0, 9'h1FF);
        rom[9'h1FF] = mk(0, 0, 0, 9'h000);
        rom[9'h011] = mk(1, 0, 1, 9'h000);
        rom[9'h142] = mk(1, 1, 0, 9'h030);

        repeat (3) @(negedge clk);
        #2;
        check(mpc == 9'h000, "R1", {11'd0, mpc}, 20'h0);
        check(mir_word == 20'h0, "R1", mir_word, 20'h0);
        rst_n = 1'b1;

        step(1, 1, 8'h00, "R1");   // zero word after reset -> 0x000
        step(0, 0, 8'h99, "R6");   // plain, opcode ignored -> 0x005
        step(1, 0, 8'h00, "R3");   // sign branch taken -> 0x110
        step(0, 1, 8'h00, "R3");   // zero branch taken -> 0x120
        step(1, 1, 8'h00, "R4");   // both enables, both flags -> 0x130
        step(1, 1, 8'h7F, "R5");   // dispatch low half -> 0x07F
        step(0, 0, 8'hA5, "R9");   // dispatch upper half -> 0x1A5
        step(1, 1, 8'h33, "R6");   // plain, flags and opcode ignored -> 0x0FF
        step(0, 0, 8'h00, "R9");   // bit 8 from field kept -> 0x1FF
        step(0, 0, 8'h00, "R2");   // -> 0x000
        step(0, 0, 8'h00, "R2");   // -> 0x005
        step(0, 1, 8'h00, "R3");   // zero flag without enable -> 0x010
        step(0, 0, 8'h00, "R2");   // -> 0x011
        step(0, 1, 8'h42, "R4");   // branch and dispatch together -> 0x142
        step(0, 0, 8'h00, "R4");   // both enables, no flags -> 0x030
        step(0, 0, 8'h00, "R2");   // -> 0x031
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #4000000;
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule